// File: doc/BRIEF.md
# Processor Power-Up Boot Sequencer

This block brings a processor core from power-on to the point where it fetches its first instruction. It waits while the system holds the core in reset or the supply is not yet good. It then walks through built-in self-test, a serial boot-ROM load and the start-up of the clock-forwarded system interface. After a fixed quiet period it enters normal run and presents the boot fetch address.

Two separate falling edges of the system-driven interface reset line pace the sequence. The first edge starts self-test on a framing-aligned cycle. The second edge, seen after the ROM load, resets the forwarded-clock interface, enables the outgoing clocks and releases internal reset in a single cycle. The self-test engine and the ROM loader sit outside the block and talk to it through simple done/pass handshakes. A 4-bit state code is brought out so that the order of the phases can be observed.

Top module: `boot_reset_seq`

## Requirements
- R1: At any clock edge where `sys_rst_n_i` is low or `pwr_good_i` is low, the next cycle shows state code 0 (hold), `core_rst_o` high, `rom_oe_n_o` high, and every other output low, including `boot_addr_o` = 0. This happens from any state.
- R2: The controller leaves hold only when `sys_rst_n_i` and `pwr_good_i` are both high at a clock edge. It then shows state code 1 (waiting for the first interface-reset release) one cycle later.
- R3: `fwd_rst_i` passes through two synchronizing flops. A high-to-low change of the synchronized value while in state 1 moves the controller to state 2 (frame alignment). `selftest_start_o` then rises exactly FRAME_CYC cycles after state 2 is entered, with state code 3. Counting the first clock edge after the input falls as edge 1, `selftest_start_o` is visible after edge FRAME_CYC+3.
- R4: `tst_stat_o` is high during self-test (state 3). It is low for exactly 16 cycles after `selftest_done_i` is sampled high (state 4). After that it stays low if `selftest_pass_i` was high with done, and goes high if it was low.
- R5: After a passing status window the controller is in state 5. There, `rom_oe_n_o` is low and `rom_load_start_o` is high until `rom_done_i` is sampled high. The controller then moves to state 6 with `rom_oe_n_o` high and `rom_load_start_o` low.
- R6: After a failing status window the controller parks in state 9 with `tst_stat_o` high. The ROM load is never started, and it stays there until R1 applies.
- R7: A synchronized falling edge of `fwd_rst_i` in state 6 is visible 3 edges after the input falls. At that point the state is 7, `link_rst_o` is high for exactly one cycle, `clk_out_en_o` is high and `core_rst_o` is low, all in the same cycle.
- R8: State 7 lasts exactly QUIET_CYC (264) cycles. The controller then shows state 8 with `run_o` high and `boot_addr_o` = 0x780.
- R9: State codes change only in the order 0, 1, 2, 3, 4, then 5, 6, 7, 8 (pass) or 9 (fail), apart from returns to 0.
- R10: Edges on `fwd_rst_i` outside states 1 and 6 have no effect. In particular, they neither start self-test while in hold nor change the state during self-test or after a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good_i | input | 1 | Supply-good indication, high when the supply is stable |
| sys_rst_n_i | input | 1 | Active-low system reset |
| fwd_rst_i | input | 1 | System-driven interface reset, active high; its falling edges pace the sequence |
| selftest_done_i | input | 1 | Self-test engine finished |
| selftest_pass_i | input | 1 | Self-test result, valid with done |
| rom_done_i | input | 1 | Boot-ROM loader finished |
| selftest_start_o | output | 1 | Self-test request, high for the whole self-test phase |
| rom_load_start_o | output | 1 | ROM-load request, high for the whole load phase |
| rom_oe_n_o | output | 1 | Active-low boot-ROM output enable |
| tst_stat_o | output | 1 | Self-test status pin |
| link_rst_o | output | 1 | One-cycle reset pulse to the forwarded-clock interface |
| clk_out_en_o | output | 1 | Outgoing clock enable |
| core_rst_o | output | 1 | Internal core reset, active high |
| run_o | output | 1 | Normal run, commands allowed |
| boot_addr_o | output | ADDR_W | Boot fetch address, 0x780 in run, otherwise 0 |
| state_o | output | 4 | Encoded sequencer state |

## Verification
A wrong internal state shows at the ports within one cycle. The state code and the decoded enables move together, so a skipped or repeated phase appears as an out-of-order state code at the next transition. A miscounted frame, status or quiet interval is caught as a start, a status release or a run flag that arrives one or more edges early or late against edge counts taken from the moment the input changed. A lost or extra synchronizer stage shifts both interface-reset responses by a cycle. Stuck or leaked enables, such as a ROM enable outside the load or clocks enabled while still in reset, appear as soon as the faulty phase is entered.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [3:0] {
    ST_HOLD       = 4'd0,
    ST_WAIT_LINK1 = 4'd1,
    ST_ALIGN      = 4'd2,
    ST_SELFTEST   = 4'd3,
    ST_STATUS     = 4'd4,
    ST_ROMLOAD    = 4'd5,
    ST_WAIT_LINK2 = 4'd6,
    ST_QUIET      = 4'd7,
    ST_RUN        = 4'd8,
    ST_FAILED     = 4'd9
  } seq_state_e;

  typedef struct packed {
    logic st_start;
    logic rom_start;
    logic rom_oe_n;
    logic status;
    logic clk_en;
    logic core_rst;
    logic run;
  } seq_out_t;

  // Output levels that belong to each state (Moore decode).
  function automatic seq_out_t seq_decode(seq_state_e s);
    seq_out_t o;
    o.st_start  = 1'b0;
    o.rom_start = 1'b0;
    o.rom_oe_n  = 1'b1;
    o.status    = 1'b0;
    o.clk_en    = 1'b0;
    o.core_rst  = 1'b1;
    o.run       = 1'b0;
    case (s)
      ST_SELFTEST: begin
        o.st_start = 1'b1;
        o.status   = 1'b1;
      end
      ST_ROMLOAD: begin
        o.rom_start = 1'b1;
        o.rom_oe_n  = 1'b0;
      end
      ST_QUIET: begin
        o.clk_en   = 1'b1;
        o.core_rst = 1'b0;
      end
      ST_RUN: begin
        o.clk_en   = 1'b1;
        o.core_rst = 1'b0;
        o.run      = 1'b1;
      end
      ST_FAILED: o.status = 1'b1;
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/boot_rst_sync.sv
// Synchronizer for the interface reset line with falling-edge detect.
// The chain is deliberately not reset, so a release is never faked by reset.
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  // chain_q[STAGES-1] is the synchronized value, chain_q[STAGES] its prior copy
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/boot_frame_timer.sv
// Free-running framing counter; flags the cycle one frame after a mark.
module boot_frame_timer #(
  parameter int FRAME_CYC = 4
) (
  input  logic clk,
  input  logic hold_i,
  input  logic mark_i,
  output logic hit_o
);
  localparam int FW = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [FW-1:0] LAST = FW'(FRAME_CYC - 1);

  logic [FW-1:0] cnt_q;
  logic [FW-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (hold_i) begin
      cnt_q  <= '0;
      mark_q <= '0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (mark_i) mark_q <= cnt_q;
    end
  end

  assign hit_o = (cnt_q == mark_q);
endmodule

// File: rtl/boot_interval.sv
// Shared down-counter for the status window and the quiet period.
module boot_interval #(
  parameter int PULSE_CYC = 16,
  parameter int QUIET_CYC = 264
) (
  input  logic clk,
  input  logic hold_i,
  input  logic load_i,
  input  logic sel_quiet_i,
  output logic done_o
);
  localparam int MAXC = (QUIET_CYC > PULSE_CYC) ? QUIET_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] QUIET_LD = CW'(QUIET_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (hold_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= sel_quiet_i ? QUIET_LD : PULSE_LD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       hold_i,
  input  logic       fall_i,
  input  logic       frame_hit_i,
  input  logic       ivl_done_i,
  input  logic       selftest_done_i,
  input  logic       selftest_pass_i,
  input  logic       rom_done_i,
  output logic       frame_mark_o,
  output logic       ivl_load_o,
  output logic       ivl_sel_quiet_o,
  output seq_out_t   out_o,
  output logic       link_rst_o,
  output logic [3:0] state_o
);
  seq_state_e state_q, nxt;
  logic       pass_q;
  seq_out_t   out_q;
  logic       link_q;

  always_comb begin
    nxt             = state_q;
    frame_mark_o    = 1'b0;
    ivl_load_o      = 1'b0;
    ivl_sel_quiet_o = 1'b0;
    case (state_q)
      ST_HOLD:       nxt = ST_WAIT_LINK1;
      ST_WAIT_LINK1: if (fall_i) begin
        nxt          = ST_ALIGN;
        frame_mark_o = 1'b1;
      end
      ST_ALIGN:      if (frame_hit_i) nxt = ST_SELFTEST;
      ST_SELFTEST:   if (selftest_done_i) begin
        nxt        = ST_STATUS;
        ivl_load_o = 1'b1;
      end
      ST_STATUS:     if (ivl_done_i) nxt = pass_q ? ST_ROMLOAD : ST_FAILED;
      ST_ROMLOAD:    if (rom_done_i) nxt = ST_WAIT_LINK2;
      ST_WAIT_LINK2: if (fall_i) begin
        nxt             = ST_QUIET;
        ivl_load_o      = 1'b1;
        ivl_sel_quiet_o = 1'b1;
      end
      ST_QUIET:      if (ivl_done_i) nxt = ST_RUN;
      default:       nxt = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (hold_i) begin
      state_q <= ST_HOLD;
      pass_q  <= 1'b0;
      out_q   <= seq_decode(ST_HOLD);
      link_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_SELFTEST && selftest_done_i) pass_q <= selftest_pass_i;
      out_q   <= seq_decode(nxt);
      link_q  <= (state_q == ST_WAIT_LINK2) && fall_i;
    end
  end

  assign out_o      = out_q;
  assign link_rst_o = link_q;
  assign state_o    = state_q;
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_seq_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter int                 FRAME_CYC   = 4,
  parameter int                 PULSE_CYC   = 16,
  parameter int                 QUIET_CYC   = 264,
  parameter int                 ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]  BOOT_ADDR   = 16'h0780
) (
  input  logic              clk,
  input  logic              pwr_good_i,
  input  logic              sys_rst_n_i,
  input  logic              fwd_rst_i,
  input  logic              selftest_done_i,
  input  logic              selftest_pass_i,
  input  logic              rom_done_i,
  output logic              selftest_start_o,
  output logic              rom_load_start_o,
  output logic              rom_oe_n_o,
  output logic              tst_stat_o,
  output logic              link_rst_o,
  output logic              clk_out_en_o,
  output logic              core_rst_o,
  output logic              run_o,
  output logic [ADDR_W-1:0] boot_addr_o,
  output logic [3:0]        state_o
);
  logic     hold;
  logic     fall;
  logic     frame_mark, frame_hit;
  logic     ivl_load, ivl_sel_quiet, ivl_done;
  seq_out_t outs;

  // System reset or a bad supply forces hold synchronously.
  assign hold = ~sys_rst_n_i | ~pwr_good_i;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .async_i (fwd_rst_i),
    .fall_o  (fall)
  );

  boot_frame_timer #(.FRAME_CYC(FRAME_CYC)) frame_i (
    .clk    (clk),
    .hold_i (hold),
    .mark_i (frame_mark),
    .hit_o  (frame_hit)
  );

  boot_interval #(.PULSE_CYC(PULSE_CYC), .QUIET_CYC(QUIET_CYC)) ivl_i (
    .clk         (clk),
    .hold_i      (hold),
    .load_i      (ivl_load),
    .sel_quiet_i (ivl_sel_quiet),
    .done_o      (ivl_done)
  );

  boot_seq_fsm fsm_i (
    .clk             (clk),
    .hold_i          (hold),
    .fall_i          (fall),
    .frame_hit_i     (frame_hit),
    .ivl_done_i      (ivl_done),
    .selftest_done_i (selftest_done_i),
    .selftest_pass_i (selftest_pass_i),
    .rom_done_i      (rom_done_i),
    .frame_mark_o    (frame_mark),
    .ivl_load_o      (ivl_load),
    .ivl_sel_quiet_o (ivl_sel_quiet),
    .out_o           (outs),
    .link_rst_o      (link_rst_o),
    .state_o         (state_o)
  );

  assign selftest_start_o = outs.st_start;
  assign rom_load_start_o = outs.rom_start;
  assign rom_oe_n_o       = outs.rom_oe_n;
  assign tst_stat_o       = outs.status;
  assign clk_out_en_o     = outs.clk_en;
  assign core_rst_o       = outs.core_rst;
  assign run_o            = outs.run;
  assign boot_addr_o      = outs.run ? BOOT_ADDR : '0;
endmodule

// File: rtl/boot_reset_seq_chk.sv
module boot_reset_seq_chk #(
  parameter int                QUIET_CYC = 264,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h0780
) (
  input logic              clk,
  input logic              pwr_good_i,
  input logic              sys_rst_n_i,
  input logic              selftest_start_o,
  input logic              rom_load_start_o,
  input logic              rom_oe_n_o,
  input logic              tst_stat_o,
  input logic              link_rst_o,
  input logic              clk_out_en_o,
  input logic              core_rst_o,
  input logic              run_o,
  input logic [ADDR_W-1:0] boot_addr_o,
  input logic [3:0]        state_o
);
  logic in_hold;
  int   quiet_cnt;

  assign in_hold = ~sys_rst_n_i | ~pwr_good_i;

  always_ff @(posedge clk) begin
    if (in_hold)                quiet_cnt <= 0;
    else if (state_o == 4'd7)   quiet_cnt <= quiet_cnt + 1;
    else                        quiet_cnt <= 0;
  end

  p_hold_outputs_r1: assert property (@(posedge clk)
    in_hold |=> (state_o == 4'd0 && core_rst_o && rom_oe_n_o && !run_o &&
                 !clk_out_en_o && !link_rst_o && !selftest_start_o));

  p_start_after_align_r3: assert property (@(posedge clk) disable iff (in_hold)
    $rose(selftest_start_o) |-> $past(state_o) == 4'd2);

  p_rom_oe_only_load_r5: assert property (@(posedge clk) disable iff (in_hold)
    !rom_oe_n_o |-> (state_o == 4'd5 && rom_load_start_o));

  p_failed_parked_r6: assert property (@(posedge clk) disable iff (in_hold)
    state_o == 4'd9 |-> (tst_stat_o && !rom_load_start_o && rom_oe_n_o));

  p_link_single_r7: assert property (@(posedge clk) disable iff (in_hold)
    link_rst_o |=> !link_rst_o);

  p_clk_vs_core_r7: assert property (@(posedge clk) disable iff (in_hold)
    clk_out_en_o |-> !core_rst_o);

  p_quiet_length_r8: assert property (@(posedge clk) disable iff (in_hold)
    (state_o == 4'd8 && $past(state_o) == 4'd7) |-> quiet_cnt == QUIET_CYC);

  p_run_addr_r8: assert property (@(posedge clk) disable iff (in_hold)
    run_o |-> (boot_addr_o == BOOT_ADDR && state_o == 4'd8));

  p_load_after_status_r9: assert property (@(posedge clk) disable iff (in_hold)
    state_o == 4'd5 |-> ($past(state_o) == 4'd4 || $past(state_o) == 4'd5));
endmodule

bind boot_reset_seq boot_reset_seq_chk #(
  .QUIET_CYC (QUIET_CYC),
  .ADDR_W    (ADDR_W),
  .BOOT_ADDR (BOOT_ADDR)
) chk_i (
  .clk              (clk),
  .pwr_good_i       (pwr_good_i),
  .sys_rst_n_i      (sys_rst_n_i),
  .selftest_start_o (selftest_start_o),
  .rom_load_start_o (rom_load_start_o),
  .rom_oe_n_o       (rom_oe_n_o),
  .tst_stat_o       (tst_stat_o),
  .link_rst_o       (link_rst_o),
  .clk_out_en_o     (clk_out_en_o),
  .core_rst_o       (core_rst_o),
  .run_o            (run_o),
  .boot_addr_o      (boot_addr_o),
  .state_o          (state_o)
);

// File: tb/boot_reset_seq_tb_top.sv
module boot_reset_seq_tb_top;
  localparam int FRAME = 4;
  localparam int PULSE = 16;
  localparam int QUIET = 264;

  logic        clk = 1'b0;
  logic        pwr_good, sys_rst_n, fwd_rst, st_done, st_pass, rom_done;
  logic        st_start, rom_start, rom_oe_n, tst_stat, link_rst, clk_en, core_rst, run;
  logic [15:0] boot_addr;
  logic [3:0]  state;

  int          n_checks = 0;
  int          n_errs   = 0;
  logic [3:0]  exp_q[$];
  logic [3:0]  last_state = 4'd0;
  bit          mon_en = 1'b0;
  bit          done_flag = 1'b0;

  always #4 clk = ~clk;

  boot_reset_seq dut_i (
    .clk (clk), .pwr_good_i (pwr_good), .sys_rst_n_i (sys_rst_n), .fwd_rst_i (fwd_rst),
    .selftest_done_i (st_done), .selftest_pass_i (st_pass), .rom_done_i (rom_done),
    .selftest_start_o (st_start), .rom_load_start_o (rom_start), .rom_oe_n_o (rom_oe_n),
    .tst_stat_o (tst_stat), .link_rst_o (link_rst), .clk_out_en_o (clk_en),
    .core_rst_o (core_rst), .run_o (run), .boot_addr_o (boot_addr), .state_o (state)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  // Scoreboard monitor: every state change must match the next expected code (R9).
  always @(negedge clk) begin
    if (mon_en && state != last_state) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected state change", int'(state), -1);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(state == e, "R9", "state order", int'(state), int'(e));
      end
      last_state = state;
    end
  end

  task automatic check_hold_outputs(input string what);
    chk(state == 4'd0, "R1", {what, " state"}, int'(state), 0);
    chk(core_rst && rom_oe_n && !run && !clk_en && !link_rst && !st_start &&
        !rom_start && !tst_stat && boot_addr == 16'h0, "R1", {what, " outputs"}, 0, 0);
  endtask

  // Hold with reset, raise power, then release reset (R1, R2).
  task automatic release_hold;
    sys_rst_n = 1'b0; pwr_good = 1'b0; fwd_rst = 1'b1;
    step(6);
    check_hold_outputs("power low");
    pwr_good = 1'b1;
    step(3);
    chk(state == 4'd0, "R1", "reset low with power good keeps hold", int'(state), 0);
    exp_q.push_back(4'd1);
    sys_rst_n = 1'b1;
    step(1);
    chk(state == 4'd1, "R2", "leave hold one cycle after release", int'(state), 1);
  endtask

  // First interface-reset release: self-test starts FRAME+3 edges later (R3).
  task automatic first_release;
    int n;
    exp_q.push_back(4'd2);
    exp_q.push_back(4'd3);
    fwd_rst = 1'b0;
    n = 0;
    do begin step(1); n++; end while (!st_start && n < 60);
    chk(n == FRAME + 3, "R3", "self-test start latency", n, FRAME + 3);
    chk(state == 4'd3, "R3", "state at self-test start", int'(state), 3);
    chk(tst_stat == 1'b1, "R4", "status high during self-test", int'(tst_stat), 1);
    fwd_rst = 1'b1;
    step(4);
    // R10: a further edge during self-test is ignored
    fwd_rst = 1'b0; step(4); fwd_rst = 1'b1; step(4);
    chk(state == 4'd3 && st_start, "R10", "edge during self-test ignored", int'(state), 3);
  endtask

  // Self-test completion and status window (R4).
  task automatic end_selftest(input bit pass);
    int cnt;
    int low;
    exp_q.push_back(4'd4);
    exp_q.push_back(pass ? 4'd5 : 4'd9);
    st_done = 1'b1; st_pass = pass;
    step(1);
    st_done = 1'b0; st_pass = 1'b0;
    cnt = 0; low = 0;
    while (state == 4'd4 && cnt < 100) begin
      cnt++;
      if (!tst_stat) low++;
      step(1);
    end
    chk(cnt == PULSE, "R4", "status window length", cnt, PULSE);
    chk(low == PULSE, "R4", "status low through window", low, PULSE);
    chk(tst_stat == !pass, "R4", "status after window", int'(tst_stat), int'(!pass));
  endtask

  initial begin
    pwr_good = 1'b0; sys_rst_n = 1'b0; fwd_rst = 1'b1;
    st_done = 1'b0; st_pass = 1'b0; rom_done = 1'b0;
    step(4);
    mon_en = 1'b1;

    // ---------------- passing boot ----------------
    release_hold;
    first_release;
    end_selftest(1'b1);
    chk(!rom_oe_n && rom_start, "R5", "ROM enable low during load", int'(rom_oe_n), 0);
    step(5);
    chk(state == 4'd5 && !rom_oe_n, "R5", "load held until done", int'(state), 5);
    exp_q.push_back(4'd6);
    rom_done = 1'b1; step(1); rom_done = 1'b0;
    chk(state == 4'd6 && rom_oe_n && !rom_start, "R5", "ROM enable released", int'(rom_oe_n), 1);
    chk(core_rst && !clk_en, "R7", "still in reset before second release", int'(core_rst), 1);
    begin
      int n;
      int q;
      exp_q.push_back(4'd7);
      exp_q.push_back(4'd8);
      fwd_rst = 1'b0;
      n = 0;
      do begin step(1); n++; end while (state != 4'd7 && n < 20);
      chk(n == 3, "R7", "second release latency", n, 3);
      chk(link_rst && clk_en && !core_rst, "R7", "link reset, clocks, core release together",
          int'({link_rst, clk_en, core_rst}), 6);
      q = 0;
      while (state == 4'd7 && q < 1000) begin
        q++;
        if (q == 2) chk(!link_rst, "R7", "link reset single cycle", int'(link_rst), 0);
        step(1);
      end
      chk(q == QUIET, "R8", "quiet period length", q, QUIET);
      chk(run && state == 4'd8, "R8", "run after quiet", int'(run), 1);
      chk(boot_addr == 16'h0780, "R8", "boot address", int'(boot_addr), 16'h0780);
    end

    // power drop in run returns to hold
    exp_q.push_back(4'd0);
    pwr_good = 1'b0;
    step(1);
    check_hold_outputs("power drop in run");

    // ---------------- failing self-test ----------------
    release_hold;
    first_release;
    end_selftest(1'b0);
    chk(state == 4'd9 && tst_stat, "R6", "parked failed with status high", int'(state), 9);
    rom_done = 1'b1; fwd_rst = 1'b0; step(2); rom_done = 1'b0; step(6); fwd_rst = 1'b1; step(6);
    chk(state == 4'd9 && !rom_start && rom_oe_n, "R6", "failure stays parked", int'(state), 9);
    exp_q.push_back(4'd0);
    sys_rst_n = 1'b0;
    step(1);
    check_hold_outputs("reset after failure");

    // R10: edges in hold do nothing
    pwr_good = 1'b1;
    fwd_rst = 1'b0; step(5); fwd_rst = 1'b1; step(5); fwd_rst = 1'b0; step(5);
    chk(state == 4'd0 && !st_start, "R10", "edges in hold ignored", int'(state), 0);
    fwd_rst = 1'b1; step(4);

    // ---------------- reset during ROM load ----------------
    release_hold;
    first_release;
    end_selftest(1'b1);
    exp_q.push_back(4'd0);
    sys_rst_n = 1'b0;
    step(1);
    check_hold_outputs("reset during ROM load");

    step(3);
    chk(exp_q.size() == 0, "R9", "all expected states seen", exp_q.size(), 0);
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary;
  end
endmodule